// File: doc/BRIEF.md
# Stipple and Blit Pixel Engine

This block is a small 2D drawing helper that sits between a 32-bit write bus and a framebuffer of 8-bit pixels. The framebuffer may also carry a 32-bit direct-colour plane and a 32-bit control plane. Each drawing operation takes two bus words. A write to an even word (address bit 2 clear) stores a colour. A write to an odd word (address bit 2 set) starts the operation. The destination pixel address is taken from the bus address itself, from bit 3 upward. The static input `blit_sel` picks the operation. In stipple mode the data word is a 32-pixel mask. In blit mode the data word holds a source address and a length, and a source of all ones turns the copy into a fill.

The engine drives a synchronous memory port and handles one pixel access per cycle. The memory returns read data one cycle after `mem_re`. A copy alternates one read and one write per pixel. `depth24` and `raw_sel` decide which planes each pixel write reaches. Both inputs are captured together with the trigger. `busy` is high for the whole operation, and a bus write offered while it is high is refused. `done` pulses in the final busy cycle.

The sequencer has six states. IDLE goes to STIP on a stipple trigger, to FILL on a fill trigger and to CRD on a copy trigger. STIP steps through 32 mask bits and then moves to DONE. FILL writes pixels until the last one and then moves to DONE. CRD always goes to CWR. CWR goes back to CRD for the next pixel, or to DONE after the last pixel. DONE always goes to IDLE.

Top module: `stipfill_engine`

## Requirements
- R1: A bus write while idle with address bit 2 clear stores the 32-bit data as the current colour. It causes no memory access and does not raise `busy`.
- R2: A bus write while idle with address bit 2 set starts an operation. The destination pixel is bus address bits [PIX_AW+2:3]. `busy` rises in the cycle after the write. Pixel addresses wrap modulo 2^PIX_AW.
- R3: In stipple mode (`blit_sel`=0), data bit 31-i controls pixel dest+i for i = 0..31. Only pixels whose bit is 1 receive the colour's low byte. The operation spends 32 cycles in STIP followed by one DONE cycle.
- R4: In blit mode (`blit_sel`=1), data bits [28:24] hold the pixel count minus one, so an operation covers 1 to 32 pixels.
- R5: In blit mode, a source field (data bits [23:0]) equal to 0xFFFFFF selects a fill. Every destination pixel receives the colour's low byte. A fill spends one cycle per pixel followed by one DONE cycle.
- R6: Any other source field selects a copy from source pixel (bits [PIX_AW-1:0] of the field). The copy issues a read cycle and then a write cycle per pixel, in ascending order, so overlapping regions follow forward-copy semantics. A read and a write never fall in the same cycle.
- R7: With `depth24`=1, every pixel write also writes the 32-bit plane. Stipple writes the full colour word, fill writes {8'h00, colour[23:0]}, and copy writes the source pixel's 32-bit word. With `depth24`=0 the 32-bit plane is never written.
- R8: With `raw_sel`=1 and `depth24`=1, every pixel write also writes the control plane. Stipple and fill write the same value as the 32-bit plane, and copy writes the source pixel's control word. Otherwise the control plane is never written.
- R9: `bus_rdata` is zero for every read, whether the engine is idle or busy.
- R10: A bus write offered while `busy` is high is refused. It leaves the colour and the running operation unchanged, and it is accepted only if it is still held once `busy` is low.
- R11: `done` is high for exactly one cycle, in the last busy cycle, and `busy` is low in the cycle after it.
- R12: `blit_sel`, `raw_sel` and `depth24` are captured at the trigger. Changing them during an operation does not alter that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | ADDR_W | Bus byte address; bit 2 selects colour or trigger, bits [PIX_AW+2:3] give the destination |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data, always zero |
| blit_sel | input | 1 | 0 = stipple, 1 = blit (captured at the trigger) |
| raw_sel | input | 1 | 1 = also write the control plane (captured at the trigger) |
| depth24 | input | 1 | 1 = also write the 32-bit plane (captured at the trigger) |
| busy | output | 1 | Operation in progress; bus writes refused |
| done | output | 1 | One-cycle pulse in the final busy cycle |
| mem_addr | output | PIX_AW | Pixel address for the read or write |
| mem_re | output | 1 | Read request; data returns next cycle |
| mem_rdata8 | input | 8 | 8-bit plane read data |
| mem_rdata32 | input | 32 | 32-bit plane read data |
| mem_rdatactl | input | 32 | Control plane read data |
| mem_we8 | output | 1 | 8-bit plane write enable |
| mem_wdata8 | output | 8 | 8-bit plane write data |
| mem_we32 | output | 1 | 32-bit plane write enable |
| mem_wdata32 | output | 32 | 32-bit plane write data |
| mem_wectl | output | 1 | Control plane write enable |
| mem_wdatactl | output | 32 | Control plane write data |

## Verification
Two things can land in the same cycle: the DONE cycle that ends an operation, and a bus write that the master has held since the operation began. The bench starts a fill and then at once presents a colour write. It keeps that write asserted through every busy cycle, DONE included, and drops it only after the first edge at which `busy` is low. It then triggers a second fill without writing a new colour. Two results judge the case. The first fill must still carry the old colour, because the held write was refused while busy. The second fill must carry the held colour, because the write was taken exactly once after DONE.

// File: rtl/stf_pkg.sv
package stf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STIP,
        ST_FILL,
        ST_CRD,
        ST_CWR,
        ST_DONE
    } stf_state_e;

    typedef struct packed {
        logic raw;
        logic deep;
    } stf_mode_t;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned SRC_W  = 24;
    localparam int unsigned LEN_LSB = 24;

endpackage

// File: rtl/stf_decode.sv
module stf_decode
    import stf_pkg::*;
#(
    parameter int unsigned PIX_AW = 20,
    parameter int unsigned ADDR_W = PIX_AW + 3,
    parameter int unsigned LEN_W  = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    input  logic                 idle,
    input  logic                 blit_sel,
    input  logic                 raw_sel,
    input  logic                 depth24,
    output logic [WORD_W-1:0]    colour_q,
    output stf_mode_t            mode_q,
    output logic [PIX_AW-1:0]    dst_q,
    output logic [PIX_AW-1:0]    src_q,
    output logic [WORD_W-1:0]    arg_q,
    output logic [LEN_W-1:0]     last_q,
    output logic                 start_stip,
    output logic                 start_fill,
    output logic                 start_copy
);

    logic accept;
    logic trig;
    logic latch;
    logic is_fill;
    logic unused_low_addr;

    assign unused_low_addr = ^bus_addr[1:0];

    assign accept  = bus_wr & idle;
    assign trig    = accept & bus_addr[2];
    assign latch   = accept & ~bus_addr[2];
    assign is_fill = (bus_wdata[SRC_W-1:0] == {SRC_W{1'b1}});

    assign start_stip = trig & ~blit_sel;
    assign start_fill = trig & blit_sel & is_fill;
    assign start_copy = trig & blit_sel & ~is_fill;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            colour_q <= '0;
        end else if (latch) begin
            colour_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            dst_q  <= '0;
            src_q  <= '0;
            arg_q  <= '0;
            last_q <= '0;
        end else if (trig) begin
            mode_q.raw  <= raw_sel;
            mode_q.deep <= depth24;
            dst_q  <= bus_addr[PIX_AW+2:3];
            src_q  <= bus_wdata[PIX_AW-1:0];
            arg_q  <= bus_wdata;
            last_q <= bus_wdata[LEN_LSB +: LEN_W];
        end
    end

    // R10
    busy_write_keeps_colour_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !idle) |=> $stable(colour_q));

    // R12
    busy_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle) |=> $stable(mode_q) || $past(idle));

endmodule

// File: rtl/stf_seq.sv
module stf_seq
    import stf_pkg::*;
#(
    parameter int unsigned BURST = 32,
    parameter int unsigned LEN_W = $clog2(BURST)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_stip,
    input  logic             start_fill,
    input  logic             start_copy,
    input  logic [LEN_W-1:0] last,
    output stf_state_e       state,
    output logic [LEN_W-1:0] idx
);

    localparam logic [LEN_W-1:0] STIP_LAST = LEN_W'(BURST - 1);

    stf_state_e       state_d;
    logic [LEN_W-1:0] idx_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            state <= state_d;
            idx   <= idx_d;
        end
    end

    always_comb begin
        state_d = state;
        idx_d   = idx;
        unique case (state)
            ST_IDLE: begin
                idx_d = '0;
                if (start_stip) begin
                    state_d = ST_STIP;
                end else if (start_fill) begin
                    state_d = ST_FILL;
                end else if (start_copy) begin
                    state_d = ST_CRD;
                end
            end
            ST_STIP: begin
                if (idx == STIP_LAST) begin
                    state_d = ST_DONE;
                end else begin
                    idx_d = idx + 1'b1;
                end
            end
            ST_FILL: begin
                if (idx == last) begin
                    state_d = ST_DONE;
                end else begin
                    idx_d = idx + 1'b1;
                end
            end
            ST_CRD: begin
                state_d = ST_CWR;
            end
            ST_CWR: begin
                if (idx == last) begin
                    state_d = ST_DONE;
                end else begin
                    state_d = ST_CRD;
                    idx_d   = idx + 1'b1;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
                idx_d   = '0;
            end
            default: begin
                state_d = ST_IDLE;
                idx_d   = '0;
            end
        endcase
    end

    // R3
    stip_walks_all_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STIP && idx != STIP_LAST) |=> (state == ST_STIP));

    // R6
    copy_alternates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CRD) |=> (state == ST_CWR) && $stable(idx));

endmodule

// File: rtl/stf_plane_drv.sv
module stf_plane_drv
    import stf_pkg::*;
#(
    parameter int unsigned PIX_AW = 20,
    parameter int unsigned BURST  = 32,
    parameter int unsigned LEN_W  = $clog2(BURST)
) (
    input  stf_state_e        state,
    input  logic [LEN_W-1:0]  idx,
    input  stf_mode_t         mode,
    input  logic [PIX_AW-1:0] dst,
    input  logic [PIX_AW-1:0] src,
    input  logic [WORD_W-1:0] colour,
    input  logic [WORD_W-1:0] mask,
    input  logic [7:0]        rd8,
    input  logic [WORD_W-1:0] rd32,
    input  logic [WORD_W-1:0] rdctl,
    output logic [PIX_AW-1:0] mem_addr,
    output logic              mem_re,
    output logic              we8,
    output logic [7:0]        wd8,
    output logic              we32,
    output logic [WORD_W-1:0] wd32,
    output logic              wectl,
    output logic [WORD_W-1:0] wdctl
);

    localparam logic [LEN_W-1:0] STIP_LAST = LEN_W'(BURST - 1);

    logic [LEN_W-1:0]  bit_sel;
    logic [PIX_AW-1:0] dst_pix;
    logic [PIX_AW-1:0] src_pix;
    logic              pix_we;

    assign bit_sel = STIP_LAST - idx;
    assign dst_pix = dst + PIX_AW'(idx);
    assign src_pix = src + PIX_AW'(idx);

    always_comb begin
        mem_addr = dst_pix;
        mem_re   = 1'b0;
        pix_we   = 1'b0;
        wd8      = colour[7:0];
        wd32     = colour;
        wdctl    = colour;
        unique case (state)
            ST_STIP: begin
                pix_we = mask[bit_sel];
            end
            ST_FILL: begin
                pix_we = 1'b1;
                wd32   = {8'h00, colour[SRC_W-1:0]};
                wdctl  = {8'h00, colour[SRC_W-1:0]};
            end
            ST_CRD: begin
                mem_addr = src_pix;
                mem_re   = 1'b1;
            end
            ST_CWR: begin
                pix_we = 1'b1;
                wd8    = rd8;
                wd32   = rd32;
                wdctl  = rdctl;
            end
            ST_IDLE, ST_DONE: begin
                pix_we = 1'b0;
            end
            default: begin
                pix_we = 1'b0;
            end
        endcase
    end

    assign we8   = pix_we;
    assign we32  = pix_we & mode.deep;
    assign wectl = pix_we & mode.deep & mode.raw;

endmodule

// File: rtl/stipfill_engine.sv
module stipfill_engine
    import stf_pkg::*;
#(
    parameter int unsigned PIX_AW = 20,
    parameter int unsigned ADDR_W = PIX_AW + 3,
    parameter int unsigned BURST  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              blit_sel,
    input  logic              raw_sel,
    input  logic              depth24,
    output logic              busy,
    output logic              done,
    output logic [PIX_AW-1:0] mem_addr,
    output logic              mem_re,
    input  logic [7:0]        mem_rdata8,
    input  logic [31:0]       mem_rdata32,
    input  logic [31:0]       mem_rdatactl,
    output logic              mem_we8,
    output logic [7:0]        mem_wdata8,
    output logic              mem_we32,
    output logic [31:0]       mem_wdata32,
    output logic              mem_wectl,
    output logic [31:0]       mem_wdatactl
);

    localparam int unsigned LEN_W = $clog2(BURST);

    stf_state_e        state;
    logic [LEN_W-1:0]  idx;
    logic [WORD_W-1:0] colour_q;
    stf_mode_t         mode_q;
    logic [PIX_AW-1:0] dst_q;
    logic [PIX_AW-1:0] src_q;
    logic [WORD_W-1:0] arg_q;
    logic [LEN_W-1:0]  last_q;
    logic              start_stip;
    logic              start_fill;
    logic              start_copy;
    logic              idle;
    logic              unused_rd;

    assign unused_rd = bus_rd;
    assign idle      = (state == ST_IDLE);
    assign busy      = ~idle;
    assign done      = (state == ST_DONE);
    assign bus_rdata = '0;

    stf_decode #(
        .PIX_AW (PIX_AW),
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .idle       (idle),
        .blit_sel   (blit_sel),
        .raw_sel    (raw_sel),
        .depth24    (depth24),
        .colour_q   (colour_q),
        .mode_q     (mode_q),
        .dst_q      (dst_q),
        .src_q      (src_q),
        .arg_q      (arg_q),
        .last_q     (last_q),
        .start_stip (start_stip),
        .start_fill (start_fill),
        .start_copy (start_copy)
    );

    stf_seq #(
        .BURST (BURST),
        .LEN_W (LEN_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_stip (start_stip),
        .start_fill (start_fill),
        .start_copy (start_copy),
        .last       (last_q),
        .state      (state),
        .idx        (idx)
    );

    stf_plane_drv #(
        .PIX_AW (PIX_AW),
        .BURST  (BURST),
        .LEN_W  (LEN_W)
    ) u_planes (
        .state    (state),
        .idx      (idx),
        .mode     (mode_q),
        .dst      (dst_q),
        .src      (src_q),
        .colour   (colour_q),
        .mask     (arg_q),
        .rd8      (mem_rdata8),
        .rd32     (mem_rdata32),
        .rdctl    (mem_rdatactl),
        .mem_addr (mem_addr),
        .mem_re   (mem_re),
        .we8      (mem_we8),
        .wd8      (mem_wdata8),
        .we32     (mem_we32),
        .wd32     (mem_wdata32),
        .wectl    (mem_wectl),
        .wdctl    (mem_wdatactl)
    );

    // R2
    busy_needs_trigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_wr && bus_addr[2]));

    // R6
    no_read_write_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we8 |-> !mem_re);

    // R6
    copy_write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CWR) |-> $past(mem_re));

    // R7
    deep_plane_follows_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we32 |-> mem_we8);

    // R8
    ctl_plane_follows_deep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wectl |-> mem_we32);

    // R11
    done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy && !done);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_we8 && !mem_re);

endmodule

// File: tb/stipfill_engine_bench.sv
module stipfill_engine_bench;

    localparam int PAW   = 10;
    localparam int AW    = PAW + 3;
    localparam int DEPTH = 1 << PAW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          blit_sel = 1'b0;
    logic          raw_sel = 1'b0;
    logic          depth24 = 1'b0;
    logic          busy;
    logic          done;
    logic [PAW-1:0] mem_addr;
    logic          mem_re;
    logic [7:0]    mem_rdata8;
    logic [31:0]   mem_rdata32;
    logic [31:0]   mem_rdatactl;
    logic          mem_we8;
    logic [7:0]    mem_wdata8;
    logic          mem_we32;
    logic [31:0]   mem_wdata32;
    logic          mem_wectl;
    logic [31:0]   mem_wdatactl;

    always #4 clk = ~clk;

    stipfill_engine #(.PIX_AW(PAW), .ADDR_W(AW), .BURST(32)) u_stipfill_engine (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .blit_sel(blit_sel), .raw_sel(raw_sel), .depth24(depth24),
        .busy(busy), .done(done), .mem_addr(mem_addr), .mem_re(mem_re),
        .mem_rdata8(mem_rdata8), .mem_rdata32(mem_rdata32), .mem_rdatactl(mem_rdatactl),
        .mem_we8(mem_we8), .mem_wdata8(mem_wdata8), .mem_we32(mem_we32),
        .mem_wdata32(mem_wdata32), .mem_wectl(mem_wectl), .mem_wdatactl(mem_wdatactl)
    );

    // memory model: synchronous, read data one cycle after mem_re
    logic [7:0]  m8 [DEPTH];
    logic [31:0] m32 [DEPTH];
    logic [31:0] mc [DEPTH];
    logic [7:0]  r8 [DEPTH];
    logic [31:0] r32 [DEPTH];
    logic [31:0] rc [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                m8[i]  <= 8'(i * 7 + 3);
                m32[i] <= {16'hC0DE, 16'(i)};
                mc[i]  <= {16'h0C7C, 16'(i)};
            end
            mem_rdata8   <= '0;
            mem_rdata32  <= '0;
            mem_rdatactl <= '0;
        end else begin
            if (mem_we8)  m8[mem_addr]  <= mem_wdata8;
            if (mem_we32) m32[mem_addr] <= mem_wdata32;
            if (mem_wectl) mc[mem_addr] <= mem_wdatactl;
            if (mem_re) begin
                mem_rdata8   <= m8[mem_addr];
                mem_rdata32  <= m32[mem_addr];
                mem_rdatactl <= mc[mem_addr];
            end
        end
    end

    typedef struct packed {
        logic        blit;
        logic        raw;
        logic        d24;
        logic [9:0]  dst;
        logic [31:0] col;
        logic [31:0] arg;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 10'd10,   32'h11223344, 32'h80000001},
        '{1'b0, 1'b0, 1'b1, 10'd100,  32'hDEADBEEF, 32'hF0F00F0F},
        '{1'b0, 1'b1, 1'b1, 10'd200,  32'h0055AA77, 32'hFFFFFFFF},
        '{1'b1, 1'b0, 1'b0, 10'd300,  32'h000000C3, 32'h00FFFFFF},
        '{1'b1, 1'b1, 1'b1, 10'd400,  32'h7F123456, 32'h1FFFFFFF},
        '{1'b1, 1'b0, 1'b0, 10'd500,  32'h00000000, 32'h0400000A},
        '{1'b1, 1'b0, 1'b1, 10'd700,  32'h00000000, 32'h1F000258},
        '{1'b1, 1'b1, 1'b1, 10'd800,  32'h00000000, 32'h070000C8},
        '{1'b1, 1'b1, 1'b1, 10'd301,  32'h00000000, 32'h0F00012C},
        '{1'b1, 1'b0, 1'b1, 10'd1020, 32'hAABBCCDD, 32'h07FFFFFF},
        '{1'b0, 1'b1, 1'b1, 10'd900,  32'h12345678, 32'h00000000}
    };

    int checks = 0;
    int failures = 0;
    logic [31:0] cur_col = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic ref_apply(input logic blit, input logic raw, input logic d24,
                             input logic [9:0] dst, input logic [31:0] col,
                             input logic [31:0] arg);
        int len;
        int d;
        int s;
        if (!blit) begin
            for (int i = 0; i < 32; i++) begin
                if (arg[31-i]) begin
                    d = (dst + i) % DEPTH;
                    r8[d] = col[7:0];
                    if (d24) begin
                        r32[d] = col;
                        if (raw) rc[d] = col;
                    end
                end
            end
        end else begin
            len = int'(arg[28:24]) + 1;
            for (int i = 0; i < len; i++) begin
                d = (dst + i) % DEPTH;
                if (arg[23:0] == 24'hFFFFFF) begin
                    r8[d] = col[7:0];
                    if (d24) begin
                        r32[d] = {8'h00, col[23:0]};
                        if (raw) rc[d] = {8'h00, col[23:0]};
                    end
                end else begin
                    s = (int'(arg[23:0]) + i) % DEPTH;
                    r8[d] = r8[s];
                    if (d24) begin
                        r32[d] = r32[s];
                        if (raw) rc[d] = rc[s];
                    end
                end
            end
        end
    endtask

    task automatic compare_mem(input string req);
        int bad = -1;
        for (int i = 0; i < DEPTH; i++) begin
            if (bad < 0 && (m8[i] !== r8[i] || m32[i] !== r32[i] || mc[i] !== rc[i])) bad = i;
        end
        if (bad < 0) check(1'b1, req, "memory", 0, 0);
        else if (m8[bad] !== r8[bad]) check(1'b0, req, $sformatf("pix8[%0d]", bad), 32'(m8[bad]), 32'(r8[bad]));
        else if (m32[bad] !== r32[bad]) check(1'b0, req, $sformatf("pix32[%0d]", bad), m32[bad], r32[bad]);
        else check(1'b0, req, $sformatf("ctl[%0d]", bad), mc[bad], rc[bad]);
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wait_idle(output int cyc, output int dn);
        cyc = 0; dn = 0;
        while (busy && cyc < 300) begin
            if (done) dn++;
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic run_op(input vec_t v, input bit send_col, input string req);
        int cyc;
        int dn;
        int exp_cyc;
        blit_sel = v.blit; raw_sel = v.raw; depth24 = v.d24;
        if (send_col) begin
            bus_write({v.dst, 3'b000}, v.col);
            cur_col = v.col;
        end
        bus_write({v.dst, 3'b100}, v.arg);
        ref_apply(v.blit, v.raw, v.d24, v.dst, cur_col, v.arg);
        wait_idle(cyc, dn);
        if (!v.blit) exp_cyc = 33;
        else if (v.arg[23:0] == 24'hFFFFFF) exp_cyc = int'(v.arg[28:24]) + 2;
        else exp_cyc = 2 * (int'(v.arg[28:24]) + 1) + 1;
        check(cyc == exp_cyc, req, "busy cycles", cyc, exp_cyc);
        check(dn == 1, "R11", "done pulses", dn, 1);
        compare_mem(req);
    endtask

    bit finished = 1'b0;

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            r8[i]  = 8'(i * 7 + 3);
            r32[i] = {16'hC0DE, 16'(i)};
            rc[i]  = {16'h0C7C, 16'(i)};
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        check(busy == 1'b0, "R11", "busy after reset", 32'(busy), 0);
        check(done == 1'b0, "R11", "done after reset", 32'(done), 0);
        check(mem_we8 == 1'b0 && mem_re == 1'b0, "R1", "memory quiet after reset", 32'({mem_we8, mem_re}), 0);

        // R9 idle read
        bus_rd = 1'b1; bus_addr = 13'h0004;
        @(negedge clk);
        check(bus_rdata == 32'h0, "R9", "idle read", bus_rdata, 0);
        bus_rd = 1'b0;

        // R1 colour latch alone does nothing visible
        bus_write(13'h0000, 32'h000000EE);
        cur_col = 32'h000000EE;
        check(busy == 1'b0, "R1", "busy after colour write", 32'(busy), 0);
        compare_mem("R1");

        // table walk: R3 stipple, R4/R5 fill, R6 copy, R7/R8 planes, R2 wrap
        for (int k = 0; k < NV; k++) begin
            string tag;
            if (!VECS[k].blit) tag = "R3";
            else if (VECS[k].arg[23:0] == 24'hFFFFFF) tag = "R5";
            else tag = "R6";
            if (VECS[k].d24) tag = {tag, VECS[k].raw ? "/R8" : "/R7"};
            if (VECS[k].dst > 10'd1000) tag = {tag, "/R2"};
            if (VECS[k].arg[28:24] == 5'd0 || VECS[k].arg[28:24] == 5'd31) tag = {tag, "/R4"};
            run_op(VECS[k], 1'b1, tag);
        end

        // R10 refused write during busy, then withdrawn
        begin
            vec_t v;
            v = '{1'b1, 1'b0, 1'b1, 10'd50, 32'h00000011, 32'h03FFFFFF};
            blit_sel = 1'b1; raw_sel = 1'b0; depth24 = 1'b1;
            bus_write({v.dst, 3'b000}, v.col);
            cur_col = v.col;
            @(negedge clk);
            bus_wr = 1'b1; bus_addr = {10'd50, 3'b100}; bus_wdata = v.arg;
            @(negedge clk);
            bus_addr = {10'd50, 3'b000}; bus_wdata = 32'h00000022;
            @(negedge clk);
            bus_rd = 1'b1;
            check(bus_rdata == 32'h0, "R9", "busy read", bus_rdata, 0);
            @(negedge clk);
            bus_wr = 1'b0; bus_rd = 1'b0;
            ref_apply(1'b1, 1'b0, 1'b1, 10'd50, cur_col, v.arg);
            while (busy) @(negedge clk);
            compare_mem("R10");
            v = '{1'b1, 1'b0, 1'b1, 10'd60, 32'h0, 32'h01FFFFFF};
            run_op(v, 1'b0, "R10");
        end

        // R12 mode inputs changed mid-operation
        begin
            blit_sel = 1'b0; raw_sel = 1'b1; depth24 = 1'b1;
            bus_write({10'd600, 3'b000}, 32'h0BADF00D);
            cur_col = 32'h0BADF00D;
            bus_write({10'd600, 3'b100}, 32'hAAAA5555);
            ref_apply(1'b0, 1'b1, 1'b1, 10'd600, cur_col, 32'hAAAA5555);
            repeat (3) @(negedge clk);
            raw_sel = 1'b0; depth24 = 1'b0; blit_sel = 1'b1;
            while (busy) @(negedge clk);
            compare_mem("R12");
        end

        // R10/R11 write held from trigger through DONE
        begin
            int held;
            blit_sel = 1'b1; raw_sel = 1'b0; depth24 = 1'b0;
            bus_write({10'd70, 3'b000}, 32'h00000033);
            cur_col = 32'h00000033;
            bus_write({10'd70, 3'b100}, 32'h02FFFFFF);
            ref_apply(1'b1, 1'b0, 1'b0, 10'd70, cur_col, 32'h02FFFFFF);
            bus_wr = 1'b1; bus_addr = {10'd70, 3'b000}; bus_wdata = 32'h00000044;
            held = 0;
            while (busy) begin held++; @(negedge clk); end
            @(negedge clk);
            bus_wr = 1'b0;
            cur_col = 32'h00000044;
            check(held == 4, "R11", "busy cycles with held write", held, 4);
            check(busy == 1'b0, "R10", "held colour write does not trigger", 32'(busy), 0);
            compare_mem("R10");
            run_op('{1'b1, 1'b0, 1'b0, 10'd80, 32'h0, 32'h01FFFFFF}, 1'b0, "R10");
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule